// File: doc/BRIEF.md
# Length-8 Polar Encoder

This block turns a 4-bit message into an 8-bit polar code word. The message bits go into the four reliable positions of an 8-entry input vector. The other four positions are frozen and hold zero. The vector is then multiplied over GF(2) by the third Kronecker power of the 2x2 polarising kernel. The multiply is done by a three-stage XOR butterfly. Each butterfly cell computes `a ^ b` on its lower leg and passes `b` through on its upper leg.

The result is registered and presented with its bits in bit-reversed index order. A valid/ready handshake accepts a message. The code word then appears one clock later with a valid flag. The code word and its flag stay put until the consumer takes them. A new message can be accepted in the same cycle that the current word is taken, so back-to-back operation runs at one word per clock.

Top module: `polar8_encoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cw_valid` is 0 and `msg_ready` is 1.
- R2: Input positions 0, 1, 2 and 4 are frozen at zero. Message bit 0 goes to position 3, bit 1 to position 5, bit 2 to position 6 and bit 3 to position 7.
- R3: The natural-order code word is x[j] = XOR of u[i] over every i whose set bits include all set bits of j. This equals u multiplied by the 3-fold Kronecker power of [[1,0],[1,1]].
- R4: Output bit k of `cw_data` carries x[r], where r is k with its three index bits reversed. For example, message 1 gives 8'h55 and message 2 gives 8'h33.
- R5: Every code word from the default frozen set has 0, 4 or 8 ones.
- R6: A message accepted on a clock edge (`msg_valid` and `msg_ready` both high) appears on `cw_data` with `cw_valid` high after that edge. The accepted message's bit 3 shows up on `cw_data[7]`.
- R7: While `cw_valid` is high and `cw_ready` is low, `cw_valid` stays high, `cw_data` is unchanged and `msg_ready` is low.
- R8: When the current word is taken and a new message is offered in the same cycle, the new word replaces it and `cw_valid` stays high. When the word is taken with no new message, `cw_valid` falls.
- R9: A message offered while `msg_ready` is low is ignored. The held code word is unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Encoder can take a message |
| msg_data | input | 4 | Message bits |
| cw_valid | output | 1 | Code word present |
| cw_ready | input | 1 | Consumer takes the code word |
| cw_data | output | 8 | Code word, bit-reversed order |

## Verification
The in-line assertions watch the timing on every cycle:
- the reset state;
- the hold of valid and data under back-pressure;
- the one-cycle load after an accepted message;
- the passage of the top message bit to the top output bit;
- the 0/4/8 weight of every word produced.

Only the bench's scenarios can show that each code word matches the direct matrix product and that the bit order is reversed rather than natural. They run all sixteen messages against an independent reference and check two hand-derived words. The bench's scenarios are also needed to show that an offer made during back-pressure leaves no trace and that the back-to-back hand-over replaces the word.

// File: rtl/polar8_encoder.sv
module polar8_encoder #(
  parameter int N = 8,
  parameter int K = 4,
  parameter logic [N-1:0] INFO_MASK = 8'b1110_1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         msg_valid,
  output logic         msg_ready,
  input  logic [K-1:0] msg_data,
  output logic         cw_valid,
  input  logic         cw_ready,
  output logic [N-1:0] cw_data
);
  localparam int LG = $clog2(N);

  function automatic int rank_of(input int pos);
    int c;
    c = 0;
    for (int b = 0; b < pos; b++) if (INFO_MASK[b]) c++;
    return c;
  endfunction

  function automatic int bitrev(input int v);
    int r;
    r = 0;
    for (int b = 0; b < LG; b++) if (((v >> b) & 1) == 1) r |= 1 << (LG - 1 - b);
    return r;
  endfunction

  logic [LG:0][N-1:0] stg;
  logic [N-1:0] cw_next;
  logic accept;

  assign msg_ready = !cw_valid || cw_ready;
  assign accept = msg_valid && msg_ready;

  for (genvar i = 0; i < N; i++) begin : g_place
    if (INFO_MASK[i]) begin : g_info
      assign stg[0][i] = msg_data[rank_of(i)];
    end else begin : g_frozen
      assign stg[0][i] = 1'b0;
    end
  end

  for (genvar s = 0; s < LG; s++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_cell
      if (((i >> s) & 1) == 0) begin : g_lo
        assign stg[s+1][i] = stg[s][i] ^ stg[s][i + (1 << s)];
      end else begin : g_hi
        assign stg[s+1][i] = stg[s][i];
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_rev
    assign cw_next[k] = stg[LG][bitrev(k)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_valid <= 1'b0;
      cw_data  <= '0;
    end else if (accept) begin
      cw_valid <= 1'b1;
      cw_data  <= cw_next;
    end else if (cw_ready) begin
      cw_valid <= 1'b0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !cw_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    cw_valid && !cw_ready |=> cw_valid && $stable(cw_data));

  a_r7_no_ready: assert property (@(posedge clk) disable iff (rst)
    cw_valid && !cw_ready |-> !msg_ready);

  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready |=> cw_valid && cw_data[N-1] == $past(msg_data[K-1]));

  if (N == 8 && INFO_MASK == 8'b1110_1000) begin : g_weight
    a_r5_weight: assert property (@(posedge clk) disable iff (rst)
      cw_valid |-> ($countones(cw_data) == 0 || $countones(cw_data) == 4
                    || $countones(cw_data) == 8));
  end
endmodule

// File: tb/polar8_encoder_test.sv
module polar8_encoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_valid = 1'b0;
  logic msg_ready;
  logic [3:0] msg_data = '0;
  logic cw_valid;
  logic cw_ready = 1'b0;
  logic [7:0] cw_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  polar8_encoder uut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_data(msg_data), .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_data(cw_data)
  );

  function automatic logic [7:0] natural_cw(input logic [3:0] m);
    logic [7:0] u, x;
    u = {m[3], m[2], m[1], 1'b0, m[0], 3'b000};
    for (int j = 0; j < 8; j++) begin
      x[j] = 1'b0;
      for (int i = 0; i < 8; i++) if ((i & j) == j) x[j] ^= u[i];
    end
    return x;
  endfunction

  function automatic logic [7:0] ref_cw(input logic [3:0] m);
    logic [7:0] x, o;
    x = natural_cw(m);
    for (int k = 0; k < 8; k++) o[k] = x[{k[0], k[1], k[2]}];
    return o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] m);
    @(negedge clk);
    msg_valid = 1'b1; msg_data = m; cw_ready = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", {31'd0, cw_valid}, 0);
    check("R1 ready", {31'd0, msg_ready}, 1);
    @(negedge clk);
    rst = 1'b0;
    check("R1 valid after", {31'd0, cw_valid}, 0);
    check("R1 ready after", {31'd0, msg_ready}, 1);
  endtask

  task automatic t_all_messages;
    for (int m = 0; m < 16; m++) begin
      send(m[3:0]);
      check("R6 valid", {31'd0, cw_valid}, 1);
      check("R2 R3 word", {24'd0, cw_data}, {24'd0, ref_cw(m[3:0])});
    end
    @(negedge clk);
    check("R8 drop", {31'd0, cw_valid}, 0);
  endtask

  task automatic t_bit_order;
    send(4'h1);
    check("R4 msg1", {24'd0, cw_data}, 32'h55);
    check("R4 not natural", {31'd0, cw_data == natural_cw(4'h1)}, 0);
    send(4'h2);
    check("R4 msg2", {24'd0, cw_data}, 32'h33);
    send(4'h8);
    check("R5 weight", $countones(cw_data), 8);
    @(negedge clk);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    msg_valid = 1'b1; msg_data = 4'h9; cw_ready = 1'b0;
    @(negedge clk);
    msg_data = 4'h6;
    check("R7 ready low", {31'd0, msg_ready}, 0);
    repeat (3) @(negedge clk);
    check("R7 valid held", {31'd0, cw_valid}, 1);
    check("R9 ignored", {24'd0, cw_data}, {24'd0, ref_cw(4'h9)});
    msg_valid = 1'b0; cw_ready = 1'b1;
    @(negedge clk);
    check("R8 taken", {31'd0, cw_valid}, 0);
  endtask

  task automatic t_back_to_back;
    send(4'h3);
    msg_valid = 1'b1; msg_data = 4'hC;
    @(negedge clk);
    msg_valid = 1'b0;
    check("R8 stays valid", {31'd0, cw_valid}, 1);
    check("R8 new word", {24'd0, cw_data}, {24'd0, ref_cw(4'hC)});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_all_messages();
    t_bit_order();
    t_backpressure();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule